// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from identical 4-bit stages chained through a terminal-count carry. The stages share one clock, one active-low clear, one active-low load and one parallel enable. The tracking enable is passed from stage to stage through the carry path. The whole chain therefore behaves as one counter of `STAGES*4` bits. There is no extra gating between stages.

Clear is asynchronous and has the highest priority. Load is synchronous and overrides both enables. Counting requires both enables to be high. When neither clear, load nor counting applies, the count holds. The top-level carry marks the all-ones state, gated by the tracking enable, so the wrapper itself can be cascaded further.

Top module: `bincnt_cascade`

## Requirements
- R1: While `clear_n` is low, `count_out` is 0 at once, without waiting for a clock edge, whatever the levels of `load_n`, `en_par` and `en_trk`.
- R2: With `clear_n` high and `load_n` low, `count_out` equals the `data_in` value present at the rising edge, regardless of `en_par` and `en_trk`.
- R3: With `clear_n` and `load_n` high and both `en_par` and `en_trk` high, each rising edge adds one to the full-width count. A stage advances only when every lower stage reads 15.
- R4: With `load_n` high and either enable low, a rising edge leaves `count_out` unchanged.
- R5: Counting from the all-ones value wraps the count to 0.
- R6: `carry_out` is 1 exactly when `count_out` is all ones and `en_trk` is 1. `en_par` has no effect on it.
- R7: When `clear_n` and `load_n` are both low at a rising edge, the count stays 0.
- R8: Changes on `en_par`, `en_trk`, `load_n` or `data_in` between rising edges leave `count_out` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages update on its rising edge |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Parallel count enable, shared by all stages |
| en_trk | input | 1 | Tracking count enable; also gates the carry |
| data_in | input | STAGES*4 | Preset value |
| count_out | output | STAGES*4 | Current count |
| carry_out | output | 1 | All ones and `en_trk` high |

## Verification
A wrong stage value appears on `count_out` right after the rising edge that produces it. It also corrupts every later expected value until the next load or clear. For this reason each cycle is compared against a bench model just after the edge.

A bad carry path between stages shows up at the 15-to-0 boundary of a lower stage: the upper stage fails to advance, or advances early. A fault in the carry gating is visible on `carry_out` within the same cycle, before any edge, so carry is checked both before and after each edge.

// File: rtl/bincnt_cascade.sv
module bincnt_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic         en_par,
  input  logic         en_trk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         tc
);
  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n)               q <= '0;
    else if (!load_n)           q <= d;
    else if (en_par && en_trk)  q <= q + 1'b1;
  end

  assign tc = en_trk && (&q);
endmodule

module bincnt_cascade #(
  parameter int STAGES = 2,
  parameter int SW     = 4,
  localparam int W     = STAGES * SW
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic         en_par,
  input  logic         en_trk,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] count_out,
  output logic         carry_out
);
  logic [STAGES:0] link;

  assign link[0] = en_trk;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    bincnt_stage #(.W(SW)) u_stage (
      .clk     (clk),
      .clear_n (clear_n),
      .load_n  (load_n),
      .en_par  (en_par),
      .en_trk  (link[i]),
      .d       (data_in[i*SW +: SW]),
      .q       (count_out[i*SW +: SW]),
      .tc      (link[i+1])
    );
  end

  assign carry_out = link[STAGES];
endmodule

// File: rtl/bincnt_cascade_chk.sv
module bincnt_cascade_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         clear_n,
  input logic         load_n,
  input logic         en_par,
  input logic         en_trk,
  input logic [W-1:0] data_in,
  input logic [W-1:0] count_out,
  input logic         carry_out
);
  AST_CLEAR_ZERO: assert property (@(posedge clk) !clear_n |-> count_out == '0); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!clear_n)
    !load_n |=> count_out == $past(data_in)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && en_par && en_trk) |=> count_out == W'($past(count_out) + 1'b1)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && !(en_par && en_trk)) |=> $stable(count_out)); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && en_par && en_trk && (&count_out)) |=> count_out == '0); // R5
  AST_CARRY_TERM: assert property (@(posedge clk) disable iff (!clear_n)
    carry_out == (en_trk && (&count_out))); // R6
endmodule

bind bincnt_cascade bincnt_cascade_chk #(.W(W)) u_chk (.*);

// File: tb/bincnt_cascade_tb_top.sv
module bincnt_cascade_tb_top;
  localparam int CLK_P  = 10;
  localparam int STAGES = 2;
  localparam int W      = STAGES * 4;

  logic clk = 1'b0;
  logic clear_n, load_n, en_par, en_trk;
  logic [W-1:0] data_in, count_out, exp_cnt;
  logic carry_out;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  bincnt_cascade #(.STAGES(STAGES)) dut_i (.*);

  function automatic logic [W-1:0] next_val(logic [W-1:0] cur, logic cl_n, logic ld_n,
                                            logic ep, logic et, logic [W-1:0] d);
    if (!cl_n) return '0;
    if (!ld_n) return d;
    if (ep && et) return cur + 1'b1;
    return cur;
  endfunction

  function automatic logic exp_carry(logic [W-1:0] cur, logic et);
    return et && (&cur);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Drive at falling edge, check carry before the edge, count after it.
  task automatic step(logic cl_n, logic ld_n, logic ep, logic et, logic [W-1:0] d, string req);
    @(negedge clk);
    clear_n = cl_n; load_n = ld_n; en_par = ep; en_trk = et; data_in = d;
    if (!cl_n) exp_cnt = '0;
    #1;
    chk("R6", W'(carry_out), W'(exp_carry(exp_cnt, et)));
    @(posedge clk);
    exp_cnt = next_val(exp_cnt, cl_n, ld_n, ep, et, d);
    #1;
    chk(req, count_out, exp_cnt);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    clear_n = 1'b0; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0; data_in = '0;
    exp_cnt = '0;
    #2;
    chk("R1", count_out, '0);
    step(1'b1, 1'b1, 1'b0, 1'b0, '0, "R4");
    // R2: load ignores enables
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, "R2");
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, "R2");
    // R4: one enable low holds
    step(1'b1, 1'b1, 1'b1, 1'b0, '0, "R4");
    step(1'b1, 1'b1, 1'b0, 1'b1, '0, "R4");
    // R3: lower stage 15 carries into upper stage
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h0F, "R2");
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R3");
    chk("R3", count_out, 8'h10);
    // R5/R6: all ones, carry gated by en_trk only, then wrap
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'hFE, "R2");
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R3");
    step(1'b1, 1'b1, 1'b0, 1'b1, '0, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b0, '0, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R5");
    chk("R5", count_out, '0);
    // R8: mid-cycle changes do not alter the count
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h42, "R2");
    #2;
    load_n = 1'b0; en_par = 1'b1; en_trk = 1'b1; data_in = 8'h99;
    #1;
    chk("R8", count_out, 8'h42);
    // R1: asynchronous clear between edges
    @(negedge clk);
    clear_n = 1'b0;
    #1;
    chk("R1", count_out, '0);
    exp_cnt = '0;
    // R7: clear beats load
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h77, "R7");
    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic cl, ld, ep, et;
      cl = ($urandom % 40) != 0;
      ld = ($urandom % 8) != 0;
      ep = ($urandom % 5) != 0;
      et = ($urandom % 5) != 0;
      step(cl, ld, ep, et, W'($urandom), "R3");
    end
    summary();
  end
endmodule